// File: doc/BRIEF.md
# Routable Two-Group Interrupt Controller

This block collects 32 level-sensitive interrupt sources, split into two groups of sixteen pins. Each cycle it copies the source levels into a pending status register. A source counts as active when its pending bit and its enable bit are both set. Each active source drives one of five CPU request lines. A limited set of pins can be moved between lines through packed 3-bit steering fields. Every other pin stays on line 0.

Software uses a plain 16-bit register port with a byte address, a write strobe, write data and combinational read data. It sets the enable masks and the steering fields. It then reads one claim register per line, which names the source to service on that line. The winner is the lowest active pin of group 1 on that line. If group 1 has none, it is the lowest active pin of group 2.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Each group's status register follows its 16 source inputs one clock later. Group 1 status is at 0x00 and group 2 status is at 0x20. Writes to these offsets have no effect.
- R2: The enable masks are read/write and reset to 0x0000. Group 1 mask is at 0x0C and group 2 mask is at 0x26. A source is active only when its status bit and its mask bit are both 1.
- R3: A steering field is 3 bits wide and holds a line number from 0 to 4. A written field value of 5, 6 or 7 leaves that field unchanged. Other fields written in the same access still update.
- R4: Each steering register packs fields at bits 2:0, 5:3, 8:6, 11:9 and 14:12. The registers are at 0x04, 0x06, 0x1C and 0x1E.
  - 0x04 fields map, in order, to group 1 pins 0, 1, 2, 3 and 8.
  - 0x06 bits 2:0, 8:6 and 11:9 serve group 1 pins 9, 11 and 12.
  - 0x1C fields map to group 2 pins 0, 1, 3, 4 and 5.
  - 0x1E fields map to group 2 pins 6 to 10.
  - Unused bits read 0, and pins without a field are fixed to line 0.
- R5: After reset, 0x04 reads 0x0040, which places group 1 pin 2 on line 1. 0x1C reads 0x0002, which places group 2 pin 0 on line 2. 0x06 and 0x1E read 0.
- R6: Output bit L of the line vector is 1 exactly when at least one active source is steered to line L. All lines are 0 after reset.
- R7: The claim register for line L is at 0x40 + 2*L. When line L has a winner, it reads bit 15 = 1, bit 4 = group (0 for group 1, 1 for group 2) and bits 3:0 = pin. It reads 0x0000 when line L has no active source.
- R8: The claim winner for a line is the lowest-numbered active pin of group 1 steered there, or if none, the lowest such pin of group 2.
- R9: A read of any offset not listed above returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| src_g1 | input | 16 | Source levels, group 1 |
| src_g2 | input | 16 | Source levels, group 2 |
| cpu_irq | output | 5 | Level requests to the five CPU lines |

## Verification
Two things can happen on the same clock edge: a source changes level, and a write moves that source's steering field to another line. The bench raises group 1 pin 0 on the same edge that rewrites its field from line 3 to line 2. After that edge only line 2 may be requested, and its claim must name that pin. Other cases also update in the same cycle: a new mask alongside new levels, and a steering word with a mix of legal and illegal fields. These are judged on the line outputs and the claim reads one cycle later.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int ADDR_W       = 8;
    localparam int DW           = 16;
    localparam int NUM_GRP      = 2;
    localparam int GRP_PINS     = 16;
    localparam int PIN_W        = $clog2(GRP_PINS);
    localparam int NUM_LINES    = 5;
    localparam int FLD_W        = 3;
    localparam int NUM_RREG     = 4;
    localparam int FLDS_PER_REG = 5;
    localparam int TOTAL_SRC    = NUM_GRP * GRP_PINS;
    localparam int SRC_IDX_W    = $clog2(TOTAL_SRC);

    localparam logic [ADDR_W-1:0] OFS_STAT1  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK1  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT2  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MASK2  = 8'h26;
    localparam logic [ADDR_W-1:0] OFS_CLAIM0 = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_STEER [NUM_RREG] = '{8'h04, 8'h06, 8'h1C, 8'h1E};

    typedef logic [FLD_W-1:0] line_sel_t;

    typedef struct packed {
        logic       ok;
        logic [1:0] reg_idx;
        logic [2:0] fld_idx;
    } steer_slot_t;

    typedef struct packed {
        logic             valid;
        logic [9:0]       rsvd;
        logic             grp;
        logic [PIN_W-1:0] pin;
    } claim_t;

    // Which steering field, if any, controls a given source.
    function automatic steer_slot_t slot_of(input int grp, input int pin);
        steer_slot_t s;
        s = '0;
        if (grp == 0) begin
            if (pin <= 3)        s = '{1'b1, 2'd0, 3'(pin)};
            else if (pin == 8)   s = '{1'b1, 2'd0, 3'd4};
            else if (pin == 9)   s = '{1'b1, 2'd1, 3'd0};
            else if (pin == 11)  s = '{1'b1, 2'd1, 3'd2};
            else if (pin == 12)  s = '{1'b1, 2'd1, 3'd3};
        end else begin
            if (pin <= 1)                   s = '{1'b1, 2'd2, 3'(pin)};
            else if (pin >= 3 && pin <= 5)  s = '{1'b1, 2'd2, 3'(pin - 1)};
            else if (pin >= 6 && pin <= 10) s = '{1'b1, 2'd3, 3'(pin - 6)};
        end
        return s;
    endfunction

    function automatic bit field_used(input int r, input int f);
        return !(r == 1 && (f == 1 || f == 4));
    endfunction

    function automatic line_sel_t field_reset(input int r, input int f);
        if (r == 0 && f == 2) return line_sel_t'(1);
        if (r == 2 && f == 0) return line_sel_t'(2);
        return '0;
    endfunction

endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
    import irq_steer_pkg::*;
(
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic [NUM_RREG-1:0]                             wr_sel,
    input  logic [DW-1:0]                                   wdata,
    output logic [NUM_RREG-1:0][FLDS_PER_REG-1:0][FLD_W-1:0] fld_q,
    output logic [NUM_RREG-1:0][DW-1:0]                     rd_word
);

    localparam int PAD_W = DW - FLDS_PER_REG * FLD_W;

    for (genvar r = 0; r < NUM_RREG; r++) begin : g_reg
        for (genvar f = 0; f < FLDS_PER_REG; f++) begin : g_fld
            localparam int LSB = f * FLD_W;
            line_sel_t q;
            if (field_used(r, f)) begin : g_used
                always_ff @(posedge clk) begin
                    if (rst)
                        q <= field_reset(r, f);
                    else if (wr_sel[r] && (wdata[LSB +: FLD_W] < FLD_W'(NUM_LINES)))
                        q <= wdata[LSB +: FLD_W];
                end
            end else begin : g_unused
                assign q = '0;
            end
            assign fld_q[r][f] = q;
        end
        assign rd_word[r] = {{PAD_W{1'b0}}, fld_q[r]};
    end

endmodule

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_steer_pkg::*;
(
    input  logic [NUM_RREG-1:0][FLDS_PER_REG-1:0][FLD_W-1:0] fld_q,
    output logic [NUM_GRP-1:0][GRP_PINS-1:0][FLD_W-1:0]      route_of
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar p = 0; p < GRP_PINS; p++) begin : g_pin
            localparam steer_slot_t S = slot_of(g, p);
            if (S.ok) begin : g_steer
                assign route_of[g][p] = fld_q[S.reg_idx][S.fld_idx];
            end else begin : g_fixed
                assign route_of[g][p] = '0;
            end
        end
    end

endmodule

// File: rtl/irq_line_pick.sv
module irq_line_pick
    import irq_steer_pkg::*;
(
    input  logic [NUM_GRP-1:0][GRP_PINS-1:0]            active,
    input  logic [NUM_GRP-1:0][GRP_PINS-1:0][FLD_W-1:0] route_of,
    output claim_t [NUM_LINES-1:0]                      claim_o
);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [TOTAL_SRC-1:0] hit;
        logic                 found;
        logic [SRC_IDX_W-1:0] idx;

        always_comb begin
            for (int g = 0; g < NUM_GRP; g++)
                for (int p = 0; p < GRP_PINS; p++)
                    hit[g*GRP_PINS + p] = active[g][p] && (route_of[g][p] == FLD_W'(l));
        end

        // Descending scan: the last match written is the lowest index,
        // and group 1 occupies the low half of the index space.
        always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = TOTAL_SRC - 1; i >= 0; i--) begin
                if (hit[i]) begin
                    found = 1'b1;
                    idx   = SRC_IDX_W'(i);
                end
            end
        end

        always_comb begin
            claim_o[l]      = '0;
            claim_o[l].valid = found;
            claim_o[l].grp   = found & idx[SRC_IDX_W-1];
            claim_o[l].pin   = found ? idx[PIN_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
    import irq_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [GRP_PINS-1:0] src_g1,
    input  logic [GRP_PINS-1:0] src_g2,
    output logic [NUM_LINES-1:0] cpu_irq
);

    logic [NUM_GRP-1:0][GRP_PINS-1:0]                  pend_q;
    logic [NUM_GRP-1:0][GRP_PINS-1:0]                  mask_q;
    logic [NUM_GRP-1:0][GRP_PINS-1:0]                  active;
    logic [NUM_RREG-1:0]                               steer_wr;
    logic [NUM_RREG-1:0][FLDS_PER_REG-1:0][FLD_W-1:0]  fld_q;
    logic [NUM_RREG-1:0][DW-1:0]                       steer_rd;
    logic [NUM_GRP-1:0][GRP_PINS-1:0][FLD_W-1:0]       route_of;
    claim_t [NUM_LINES-1:0]                            claim;
    logic [NUM_LINES-1:0]                              claim_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= {src_g2, src_g1};
            if (reg_wr && reg_addr == OFS_MASK1) mask_q[0] <= reg_wdata;
            if (reg_wr && reg_addr == OFS_MASK2) mask_q[1] <= reg_wdata;
        end
    end

    assign active = pend_q & mask_q;

    for (genvar r = 0; r < NUM_RREG; r++) begin : g_wsel
        assign steer_wr[r] = reg_wr && (reg_addr == OFS_STEER[r]);
    end

    irq_steer_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (steer_wr),
        .wdata   (reg_wdata),
        .fld_q   (fld_q),
        .rd_word (steer_rd)
    );

    irq_src_map u_map (
        .fld_q    (fld_q),
        .route_of (route_of)
    );

    irq_line_pick u_pick (
        .active   (active),
        .route_of (route_of),
        .claim_o  (claim)
    );

    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) begin
            cpu_irq[l] = 1'b0;
            for (int g = 0; g < NUM_GRP; g++)
                for (int p = 0; p < GRP_PINS; p++)
                    if (active[g][p] && route_of[g][p] == FLD_W'(l))
                        cpu_irq[l] = 1'b1;
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_cv
        assign claim_valid[l] = claim[l].valid;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STAT1: reg_rdata = pend_q[0];
            OFS_MASK1: reg_rdata = mask_q[0];
            OFS_STAT2: reg_rdata = pend_q[1];
            OFS_MASK2: reg_rdata = mask_q[1];
            default:   reg_rdata = '0;
        endcase
        for (int r = 0; r < NUM_RREG; r++)
            if (reg_addr == OFS_STEER[r]) reg_rdata = steer_rd[r];
        for (int l = 0; l < NUM_LINES; l++)
            if (reg_addr == ADDR_W'(OFS_CLAIM0 + 2 * l)) reg_rdata = claim[l];
    end

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
    import irq_steer_pkg::*;
(
    input logic                                            clk,
    input logic                                            rst,
    input logic [ADDR_W-1:0]                               reg_addr,
    input logic                                            reg_wr,
    input logic [DW-1:0]                                   reg_wdata,
    input logic [DW-1:0]                                   reg_rdata,
    input logic [GRP_PINS-1:0]                             src_g1,
    input logic [GRP_PINS-1:0]                             src_g2,
    input logic [NUM_LINES-1:0]                            cpu_irq,
    input logic [NUM_GRP-1:0][GRP_PINS-1:0]                pend_q,
    input logic [NUM_GRP-1:0][GRP_PINS-1:0]                mask_q,
    input logic [NUM_RREG-1:0][FLDS_PER_REG-1:0][FLD_W-1:0] fld_q,
    input logic [NUM_LINES-1:0]                            claim_valid
);

    // R1: status mirrors the inputs of the previous cycle
    assert_status_track_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pend_q == {$past(src_g2), $past(src_g1)});

    // R2: masks come out of reset cleared
    assert_mask_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mask_q == '0);

    // R3: an out-of-range value in the first field of 0x04 is dropped
    assert_illegal_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h04 && reg_wdata[2:0] > 3'd4) |=> $stable(fld_q[0][0]));

    // R3: no field ever holds a line number above 4
    for (genvar r = 0; r < NUM_RREG; r++) begin : g_r
        for (genvar f = 0; f < FLDS_PER_REG; f++) begin : g_f
            assert_field_range_R3: assert property (@(posedge clk) disable iff (rst)
                fld_q[r][f] < FLD_W'(NUM_LINES));
        end
    end

    // R6: no request lines right after reset
    assert_line_reset_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cpu_irq == '0);

    // R7: a line is requested exactly when its claim reports a winner
    assert_line_claim_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == claim_valid);

    // R9: sample unmapped offsets read zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h02 || reg_addr == 8'h4A || reg_addr == 8'h08) |-> reg_rdata == '0);

endmodule

bind irq_steer_ctrl irq_steer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .src_g1      (src_g1),
    .src_g2      (src_g2),
    .cpu_irq     (cpu_irq),
    .pend_q      (pend_q),
    .mask_q      (mask_q),
    .fld_q       (fld_q),
    .claim_valid (claim_valid)
);

// File: tb/test_irq_steer_ctrl.sv
module test_irq_steer_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] src_g1 = '0;
    logic [15:0] src_g2 = '0;
    logic [4:0]  cpu_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    irq_steer_ctrl i_irq_steer_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_g1    (src_g1),
        .src_g2    (src_g2),
        .cpu_irq   (cpu_irq)
    );

    typedef struct packed {
        logic [15:0] m1;
        logic [15:0] m2;
        logic [15:0] r1;
        logic [15:0] r2;
        logic [4:0]  lines;
        logic [15:0] claim0;
    } vec_t;

    // Default steering: g1 pin2 -> line1, g2 pin0 -> line2, all else line0.
    localparam vec_t VECS [8] = '{
        '{16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 5'b00000, 16'h0000},
        '{16'hFFFF, 16'h0000, 16'h0004, 16'h0001, 5'b00010, 16'h0000},
        '{16'hFFFF, 16'hFFFF, 16'h0004, 16'h0001, 5'b00110, 16'h0000},
        '{16'hFFFF, 16'hFFFF, 16'h0010, 16'h0000, 5'b00001, 16'h8004},
        '{16'hFFEF, 16'hFFFF, 16'h0030, 16'h0000, 5'b00001, 16'h8005},
        '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h0100, 5'b00001, 16'h8018},
        '{16'h8000, 16'hFFFF, 16'h8000, 16'h0006, 5'b00001, 16'h800F},
        '{16'h0000, 16'hFFFE, 16'h0000, 16'h0007, 5'b00001, 16'h8011}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // Reset state
        check("R6 lines after reset", 16'(cpu_irq), 16'h0000);
        rd_check("R2 mask1 reset", 8'h0C, 16'h0000);
        rd_check("R2 mask2 reset", 8'h26, 16'h0000);
        rd_check("R5 steer 0x04 reset", 8'h04, 16'h0040);
        rd_check("R5 steer 0x06 reset", 8'h06, 16'h0000);
        rd_check("R5 steer 0x1C reset", 8'h1C, 16'h0002);
        rd_check("R5 steer 0x1E reset", 8'h1E, 16'h0000);
        rd_check("R7 claim0 idle", 8'h40, 16'h0000);
        @(negedge clk);

        // Vector table: masking, line OR, claim priority (R2 R6 R7 R8)
        foreach (VECS[i]) begin
            wr(8'h0C, VECS[i].m1);
            wr(8'h26, VECS[i].m2);
            src_g1 = VECS[i].r1;
            src_g2 = VECS[i].r2;
            tick();
            check($sformatf("R6 vec%0d lines", i), 16'(cpu_irq), 16'(VECS[i].lines));
            rd_check($sformatf("R8 vec%0d claim0", i), 8'h40, VECS[i].claim0);
            @(negedge clk);
        end

        // R1: status follows inputs, writes ignored
        src_g1 = 16'h1234;
        src_g2 = 16'h00A5;
        tick();
        rd_check("R1 status1", 8'h00, 16'h1234);
        rd_check("R1 status2", 8'h20, 16'h00A5);
        @(negedge clk);
        wr(8'h00, 16'hFFFF);
        wr(8'h20, 16'h0000);
        rd_check("R1 status1 after write", 8'h00, 16'h1234);
        rd_check("R1 status2 after write", 8'h20, 16'h00A5);

        // R9: unmapped offsets
        rd_check("R9 offset 0x02", 8'h02, 16'h0000);
        rd_check("R9 offset 0x4A", 8'h4A, 16'h0000);
        rd_check("R9 offset 0x08", 8'h08, 16'h0000);
        @(negedge clk);

        // R3: mixed legal/illegal fields
        wr(8'h04, 16'h213B);
        rd_check("R3 steer 0x04 partial", 8'h04, 16'h2103);
        @(negedge clk);
        wr(8'h06, 16'hFFFF);
        rd_check("R3 steer 0x06 all illegal", 8'h06, 16'h0000);
        @(negedge clk);
        wr(8'h06, 16'h76B9);
        rd_check("R4 steer 0x06 unused bits", 8'h06, 16'h0681);
        @(negedge clk);

        // R4: group 1 steering effect
        src_g1 = 16'h0000;
        src_g2 = 16'h0000;
        wr(8'h0C, 16'hFFFF);
        wr(8'h26, 16'h0000);
        src_g1 = 16'h0204;
        tick();
        check("R4 g1 lines", 16'(cpu_irq), 16'h0012);
        rd_check("R4 claim1 g1 pin9", 8'h42, 16'h8009);
        rd_check("R4 claim4 g1 pin2", 8'h48, 16'h8002);
        @(negedge clk);

        // R4: group 2 steering effect
        wr(8'h1E, 16'h0003);
        wr(8'h26, 16'hFFFF);
        src_g1 = 16'h0000;
        src_g2 = 16'h0041;
        tick();
        check("R4 g2 lines", 16'(cpu_irq), 16'h000C);
        rd_check("R4 claim3 g2 pin6", 8'h46, 16'h8016);
        rd_check("R7 claim2 g2 pin0", 8'h44, 16'h8010);
        @(negedge clk);

        // Same edge: source rises while its field moves line 3 -> line 2
        src_g2 = 16'h0000;
        tick();
        reg_addr  = 8'h04;
        reg_wdata = 16'h2102;
        reg_wr    = 1'b1;
        src_g1    = 16'h0001;
        tick();
        reg_wr    = 1'b0;
        #1;
        check("R6 same-edge lines", 16'(cpu_irq), 16'h0004);
        rd_check("R3 same-edge claim2", 8'h44, 16'h8000);
        rd_check("R7 claim0 empty", 8'h40, 16'h0000);
        rd_check("R7 claim3 empty", 8'h46, 16'h0000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule